// File: doc/BRIEF.md
# CD Sector Buffer Controller

This block sits between a CD drive front end and a small 16-bit local RAM. Raw sectors arrive one 16-bit word at a time with a valid strobe. The block drops the sync field at the start of each sector. It then steers the rest of the sector into one of two data buffers or one of two ADPCM audio buffers in the RAM. The choice depends on the active command and on the sector's subheader. When a sector has been completely written, the block flips a buffer-select bit and raises an interrupt.

A host CPU programs the block through a small word-indexed register file. The command register does not act on its own: the CPU must write the control register with a trigger bit set, and that copies the command into the active command register. The run bit in the control register gates all sector processing. Audio sectors in mode 2 are admitted only when the file byte matches and the channel number hits a set bit in both the channel mask and the audio channel mask. Seeking, DMA and audio decoding are handled elsewhere.

Top module: `cd_sector_steer`

## Requirements
- R1: After reset, no RAM write occurs, `irq` is low, and both the control register (index 7) and the status register (index 8) read 0. The other register indices are:
  - 0: command.
  - 1 and 2: time, high and low.
  - 3: file.
  - 4 and 5: channel mask, high and low; the high word covers channels 16 to 31.
  - 6: audio channel mask.
- R2: Writing the command register alone does not change the behaviour. Only a control write with bit 15 set copies the low byte of the command register into the active command.
- R3: While control bit 14 (run) is 0, incoming words produce no RAM write and no interrupt, and the buffer-select bits stay as they are. Sector framing restarts at word 0 once run is set again.
- R4: The first SYNC_WORDS words of every sector are not stored. Word k after the sync field is written to the word address `base + k`. The bases are:
  - data buffer 0 at 0, data buffer 1 at BUF_WORDS.
  - ADPCM buffer 0 at 4*BUF_WORDS, ADPCM buffer 1 at 5*BUF_WORDS.
- R5: A delivered data sector goes to data buffer 1 when control bit 0 is 0, and to buffer 0 when it is 1. Control bit 0 then toggles, so it always names the buffer that holds the newest sector.
- R6: In mode 2 (active command 0x24 or 0x2A), a sector whose submode byte has bit 2 set (word bit 10 of header word 3) is an audio sector. It is stored only when all of the following hold:
  - the high byte of the file register equals the file byte (header word 2, bits 15:8);
  - the channel byte (header word 2, bits 7:0) is below 32 and selects a set bit of the channel mask;
  - the channel byte is below 16 and selects a set bit of the audio channel mask.

  An accepted audio sector goes to ADPCM buffer 1 when status bit 0 is 0, and to ADPCM buffer 0 when it is 1. Status bit 0 then toggles, and control bit 0 stays unchanged.
- R7: An audio sector refused under R6 causes no RAM write and no interrupt, and changes no select bit.
- R8: The following sectors go to the data buffers whatever the masks hold:
  - in mode 1 (0x23, 0x29), every sector;
  - in mode 2, every sector that is not audio.
- R9: Under active command 0x28 (CDDA), every sector goes to the data buffers and toggles control bit 0. An interrupt is raised only when the frame byte (header word 1, bits 15:8) is zero.
- R10: While the command register holds 0x23 or 0x24, reading stops after the next delivered sector. Later sectors are ignored until a new trigger.
- R11: Active command 0x2B, or any code that is not a read command, admits no sector.
- R12: `irq` rises after each delivered sector, except as limited by R9. Status bit 15 mirrors `irq`, and a CPU read of index 8 clears it.
- R13: The trigger bit (control bit 15) reads back as 1 in the cycle after the write and as 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_en | input | 1 | CPU access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 4 | Register index |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for the register at `cpu_addr` (combinational) |
| sec_valid | input | 1 | Sector word strobe |
| sec_word | input | 16 | Sector word |
| ram_we | output | 1 | Local RAM write enable |
| ram_addr | output | AW | Local RAM word address |
| ram_wdata | output | 16 | Local RAM write data |
| irq | output | 1 | Sector-delivered interrupt |

## Verification
The hardest case to reach from the ports is the deferred write of the four header words. The target buffer is known only when the submode word arrives, so those four words are written into cycles left free by the body of the sector. Any free cycles that remain come after the last body word. The stimulus therefore sends whole sectors back to back, with no gap inside a sector, and checks every stored word, including the header words, at its computed address. A sweep over channel numbers 0 to 19, 34, and a file mismatch exercises the three-way acceptance rule against masks whose bits differ between the two masks.

// File: rtl/cd_sector_steer.sv
module cd_sector_steer #(
  parameter int AW           = 13,
  parameter int BUF_WORDS    = 1280,
  parameter int SECTOR_WORDS = 1176,
  parameter int SYNC_WORDS   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_en,
  input  logic          cpu_we,
  input  logic [3:0]    cpu_addr,
  input  logic [15:0]   cpu_wdata,
  output logic [15:0]   cpu_rdata,
  input  logic          sec_valid,
  input  logic [15:0]   sec_word,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [15:0]   ram_wdata,
  output logic          irq
);

  localparam int CW = $clog2(SECTOR_WORDS);
  localparam logic [CW-1:0] LAST = CW'(SECTOR_WORDS - 1);
  localparam logic [CW-1:0] SYNC = CW'(SYNC_WORDS);
  localparam logic [CW-1:0] DEC  = CW'(SYNC_WORDS + 3);
  localparam logic [CW-1:0] BODY = CW'(SYNC_WORDS + 4);
  localparam logic [AW-1:0] DATA0 = '0;
  localparam logic [AW-1:0] DATA1 = AW'(BUF_WORDS);
  localparam logic [AW-1:0] DEND  = AW'(2 * BUF_WORDS);
  localparam logic [AW-1:0] ADP0  = AW'(4 * BUF_WORDS);
  localparam logic [AW-1:0] ADP1  = AW'(5 * BUF_WORDS);
  localparam logic [AW-1:0] AEND  = AW'(6 * BUF_WORDS);

  localparam logic [3:0] A_CMD = 4'd0, A_TH = 4'd1, A_TL = 4'd2, A_FILE = 4'd3;
  localparam logic [3:0] A_CMH = 4'd4, A_CML = 4'd5, A_AM = 4'd6, A_CTRL = 4'd7, A_XBUF = 4'd8;

  localparam logic [7:0] C_RST1 = 8'h23, C_RST2 = 8'h24, C_CDDA = 8'h28;
  localparam logic [7:0] C_RD1 = 8'h29, C_RD2 = 8'h2A;

  logic [15:0] cmd_r, time_hi, time_lo, file_r, chm_hi, chm_lo, amask_r;
  logic [14:1] ctrl_r;
  logic [7:0]  shadow;
  logic        trig, dsel, asel, last_audio, irq_r, reading;
  logic [CW-1:0] in_cnt;
  logic        live, acc, data_done, tgt_audio, tgt_irq;
  logic [2:0]  hp;
  logic [AW-1:0] tgt_base;
  logic [15:0] hdr [4];

  wire run    = ctrl_r[14];
  wire cpu_wr = cpu_en & cpu_we;
  wire cpu_rd = cpu_en & ~cpu_we;
  wire [CW-1:0] off = in_cnt - SYNC;

  wire [31:0] chm     = {chm_hi, chm_lo};
  wire [7:0]  ch_id   = hdr[2][7:0];
  wire        file_ok = file_r[15:8] == hdr[2][15:8];
  wire        ch_ok   = (ch_id < 8'd32) && chm[ch_id[4:0]];
  wire        au_ok   = (ch_id < 8'd16) && amask_r[ch_id[3:0]];
  wire        m_cdda  = shadow == C_CDDA;
  wire        m_two   = (shadow == C_RST2) || (shadow == C_RD2);
  wire        to_audio = m_two && sec_word[10];
  wire        accept  = live && (!to_audio || (file_ok && ch_ok && au_ok));
  wire [AW-1:0] new_base = to_audio ? (asel ? ADP0 : ADP1) : (dsel ? DATA0 : DATA1);
  wire        new_irq = !m_cdda || (hdr[1][15:8] == 8'h00);

  wire        direct_we = sec_valid && acc && (in_cnt >= BODY);
  wire        flush_we  = (hp != 3'd0) && !direct_we;
  wire        fire      = run && data_done && (hp == 3'd0);
  wire [2:0]  fidx      = 3'd4 - hp;
  wire        stop_cmd  = (cmd_r[7:0] == C_RST1) || (cmd_r[7:0] == C_RST2);

  function automatic logic is_read(input logic [7:0] c);
    return (c == C_RST1) || (c == C_RST2) || (c == C_CDDA) || (c == C_RD1) || (c == C_RD2);
  endfunction

  assign ram_we    = run && (direct_we || flush_we);
  assign ram_addr  = direct_we ? tgt_base + AW'(off) : tgt_base + AW'(fidx);
  assign ram_wdata = direct_we ? sec_word : hdr[fidx[1:0]];
  assign irq       = irq_r;

  always_comb begin
    case (cpu_addr)
      A_CMD:   cpu_rdata = cmd_r;
      A_TH:    cpu_rdata = time_hi;
      A_TL:    cpu_rdata = time_lo;
      A_FILE:  cpu_rdata = file_r;
      A_CMH:   cpu_rdata = chm_hi;
      A_CML:   cpu_rdata = chm_lo;
      A_AM:    cpu_rdata = amask_r;
      A_CTRL:  cpu_rdata = {trig, ctrl_r, dsel};
      A_XBUF:  cpu_rdata = {irq_r, 13'd0, last_audio, asel};
      default: cpu_rdata = 16'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_r <= '0; time_hi <= '0; time_lo <= '0; file_r <= '0;
      chm_hi <= '0; chm_lo <= '0; amask_r <= '0; ctrl_r <= '0;
      shadow <= '0; trig <= 1'b0; dsel <= 1'b0; asel <= 1'b0;
      last_audio <= 1'b0; irq_r <= 1'b0; reading <= 1'b0;
      in_cnt <= '0; live <= 1'b0; acc <= 1'b0; data_done <= 1'b0;
      tgt_audio <= 1'b0; tgt_irq <= 1'b0; hp <= '0; tgt_base <= '0;
      for (int i = 0; i < 4; i++) hdr[i] <= '0;
    end else begin
      if (cpu_rd && cpu_addr == A_XBUF) irq_r <= 1'b0;

      if (sec_valid) begin
        in_cnt <= (in_cnt == LAST) ? '0 : in_cnt + 1'b1;
        if (in_cnt >= SYNC && in_cnt < BODY) hdr[off[1:0]] <= sec_word;
        if (in_cnt == SYNC) live <= reading;
        if (in_cnt == DEC && accept) begin
          acc       <= 1'b1;
          hp        <= 3'd4;
          tgt_base  <= new_base;
          tgt_audio <= to_audio;
          tgt_irq   <= new_irq;
        end
        if (in_cnt == LAST) begin
          if (acc) data_done <= 1'b1;
          acc <= 1'b0;
        end
      end

      if (flush_we) hp <= hp - 3'd1;

      if (fire) begin
        data_done  <= 1'b0;
        last_audio <= tgt_audio;
        if (tgt_audio) asel <= ~asel;
        else           dsel <= ~dsel;
        if (tgt_irq) irq_r <= 1'b1;
        if (stop_cmd) reading <= 1'b0;
      end

      if (trig) begin
        trig    <= 1'b0;
        shadow  <= cmd_r[7:0];
        reading <= is_read(cmd_r[7:0]);
      end

      if (cpu_wr) begin
        case (cpu_addr)
          A_CMD:  cmd_r   <= cpu_wdata;
          A_TH:   time_hi <= cpu_wdata;
          A_TL:   time_lo <= cpu_wdata;
          A_FILE: file_r  <= cpu_wdata;
          A_CMH:  chm_hi  <= cpu_wdata;
          A_CML:  chm_lo  <= cpu_wdata;
          A_AM:   amask_r <= cpu_wdata;
          A_CTRL: begin
            ctrl_r <= cpu_wdata[14:1];
            if (cpu_wdata[15]) trig <= 1'b1;
          end
          default: ;
        endcase
      end

      if (!run) begin
        in_cnt    <= '0;
        live      <= 1'b0;
        acc       <= 1'b0;
        hp        <= '0;
        data_done <= 1'b0;
      end
    end
  end

  AST_TRIG_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);  // R13
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> $stable(shadow));  // R2
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !ram_we);  // R3
  AST_WRITE_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr < DEND) || (ram_addr >= ADP0 && ram_addr < AEND));  // R4
  AST_DATA_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !tgt_audio) |-> ram_addr < DEND);  // R8
  AST_AUDIO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && tgt_audio) |-> ram_addr >= ADP0);  // R6
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(dsel) && $stable(asel)));  // R5
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == A_XBUF && !fire) |=> !irq);  // R12

endmodule

// File: tb/tb_cd_sector_steer.sv
module tb_cd_sector_steer;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int SY = 6;
  localparam int BW = 1280;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_en = 1'b0, cpu_we = 1'b0;
  logic [3:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0, cpu_rdata;
  logic sec_valid = 1'b0;
  logic [15:0] sec_word = '0;
  logic ram_we, irq;
  logic [12:0] ram_addr;
  logic [15:0] ram_wdata;

  cd_sector_steer #(.AW(13), .BUF_WORDS(BW), .SECTOR_WORDS(SW), .SYNC_WORDS(SY)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sec_valid(sec_valid), .sec_word(sec_word),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] mem [0:8191];
  int wcount = 0, checks = 0, fails = 0;
  bit done = 1'b0;
  bit edsel = 1'b0, easel = 1'b0;

  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (ram_we) begin
      mem[ram_addr] = ram_wdata;
      wcount++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [15:0] d);
    cpu_addr = a;
    #1;
    d = cpu_rdata;
  endtask

  task automatic clear_irq();
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = 1'b0; cpu_addr = 4'd8;
    @(negedge clk);
    cpu_en = 1'b0;
  endtask

  function automatic logic [15:0] gen(input int i, input logic [7:0] seed,
                                      input logic [15:0] w1, input logic [15:0] w2, input logic [15:0] w3);
    if (i < SY) return (i == 0) ? 16'h00FF : ((i == SY - 1) ? 16'hFF00 : 16'hFFFF);
    case (i - SY)
      0: return {8'h02, seed};
      1: return w1;
      2: return w2;
      3: return w3;
      4: return w2;
      5: return w3;
      default: return {seed, 8'(i)};
    endcase
  endfunction

  task automatic run_sector(input string req, input logic [7:0] seed, input logic [15:0] w1,
                            input logic [15:0] w2, input logic [15:0] w3,
                            input bit exp_acc, input bit audio, input bit exp_irq);
    int wc0;
    int base;
    logic [15:0] r;
    base = audio ? (easel ? 4*BW : 5*BW) : (edsel ? 0 : BW);
    wc0 = wcount;
    for (int i = 0; i < SW; i++) begin
      @(negedge clk);
      sec_valid = 1'b1;
      sec_word = gen(i, seed, w1, w2, w3);
    end
    @(negedge clk);
    sec_valid = 1'b0;
    repeat (12) @(negedge clk);
    if (exp_acc) begin
      check(wcount - wc0 == SW - SY, req, wcount - wc0, SW - SY);
      for (int k = 0; k < SW - SY; k++)
        check(mem[base + k] == gen(SY + k, seed, w1, w2, w3), req, mem[base + k], gen(SY + k, seed, w1, w2, w3));
      if (audio) easel = ~easel; else edsel = ~edsel;
    end else begin
      check(wcount == wc0, req, wcount - wc0, 0);
    end
    check(irq == (exp_acc && exp_irq), req, irq, exp_acc && exp_irq);
    peek(4'd8, r);
    check(r[15] == irq, "R12", r[15], irq);
    check(r[0] == easel, req, r[0], easel);
    peek(4'd7, r);
    check(r[0] == edsel, req, r[0], edsel);
    if (irq) begin
      clear_irq();
      #1;
      check(irq == 1'b0, "R12", irq, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [31:0] chm;
    logic [15:0] am;
    bit ok;
    chm = {16'h0004, 16'hA5C3};
    am = 16'h3F0F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek(4'd7, r); check(r == 16'h0000, "R1", r, 0);
    peek(4'd8, r); check(r == 16'h0000, "R1", r, 0);
    check(irq == 1'b0, "R1", irq, 0);
    check(wcount == 0, "R1", wcount, 0);

    // R13 trigger self-clear
    cpu_write(4'd0, 16'h0029);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = 1'b1; cpu_addr = 4'd7; cpu_wdata = 16'hC000;
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0;
    peek(4'd7, r); check(r == 16'hC000, "R13", r, 16'hC000);
    @(negedge clk);
    peek(4'd7, r); check(r == 16'h4000, "R13", r, 16'h4000);

    // R4 R5 R8 mode 1: data buffers alternate, audio submode irrelevant
    run_sector("R4", 8'h11, 16'h0502, 16'h0100, 16'h0800, 1, 0, 1);
    run_sector("R5", 8'h12, 16'h0602, 16'h0100, 16'h0800, 1, 0, 1);
    run_sector("R8", 8'h13, 16'h0702, 16'h0705, 16'h6411, 1, 0, 1);

    // mode 2 with masks
    cpu_write(4'd3, 16'h0100);
    cpu_write(4'd4, chm[31:16]);
    cpu_write(4'd5, chm[15:0]);
    cpu_write(4'd6, am);
    cpu_write(4'd0, 16'h002A);
    cpu_write(4'd7, 16'hC000);
    peek(4'd5, r); check(r == chm[15:0], "R1", r, chm[15:0]);
    for (int ch = 0; ch < 20; ch++) begin
      ok = chm[ch] && (ch < 16) && am[ch[3:0]];
      run_sector(ok ? "R6" : "R7", 8'(8'h20 + ch), 16'h0802, {8'h01, 8'(ch)}, 16'h6411, ok, 1, 1);
    end
    run_sector("R7", 8'h40, 16'h0802, {8'h01, 8'd34}, 16'h6411, 0, 1, 1);
    run_sector("R7", 8'h41, 16'h0802, {8'h02, 8'd0}, 16'h6411, 0, 1, 1);
    run_sector("R8", 8'h42, 16'h0802, {8'h07, 8'd5}, 16'h0800, 1, 0, 1);

    // R2 command without trigger has no effect
    cpu_write(4'd0, 16'h0028);
    peek(4'd0, r); check(r == 16'h0028, "R1", r, 16'h0028);
    run_sector("R2", 8'h50, 16'h0502, {8'h01, 8'd5}, 16'h6411, 0, 1, 1);
    cpu_write(4'd7, 16'hC000);
    // R9 CDDA
    run_sector("R9", 8'h51, 16'h0502, {8'h01, 8'd5}, 16'h6411, 1, 0, 0);
    run_sector("R9", 8'h52, 16'h0002, {8'h01, 8'd5}, 16'h6411, 1, 0, 1);

    // R3 halt
    cpu_write(4'd7, 16'h0000);
    run_sector("R3", 8'h60, 16'h0002, 16'h0100, 16'h0800, 0, 0, 1);
    cpu_write(4'd7, 16'h4000);
    run_sector("R3", 8'h61, 16'h0002, 16'h0100, 16'h0800, 1, 0, 1);

    // R11 stop
    cpu_write(4'd0, 16'h002B);
    cpu_write(4'd7, 16'hC000);
    run_sector("R11", 8'h70, 16'h0002, 16'h0100, 16'h0800, 0, 0, 1);

    // R10 stop after next sector
    cpu_write(4'd0, 16'h0024);
    cpu_write(4'd7, 16'hC000);
    run_sector("R10", 8'h80, 16'h0002, 16'h0100, 16'h0800, 1, 0, 1);
    run_sector("R10", 8'h81, 16'h0002, 16'h0100, 16'h0800, 0, 0, 1);
    cpu_write(4'd0, 16'h0029);
    cpu_write(4'd7, 16'hC000);
    run_sector("R10", 8'h82, 16'h0002, 16'h0100, 16'h0800, 1, 0, 1);
    cpu_write(4'd0, 16'h0023);
    run_sector("R10", 8'h83, 16'h0002, 16'h0100, 16'h0800, 1, 0, 1);
    run_sector("R10", 8'h84, 16'h0002, 16'h0100, 16'h0800, 0, 0, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule